// File: doc/BRIEF.md
# Accumulator-Index Multi-Cycle CPU Core

A compact multi-cycle processor core with two 16-bit programmer registers, an accumulator (A) and an index register (X), together with a program counter, an instruction register and four status flags (N, Z, V, C). It runs programs held in a byte-addressed memory with a 16-bit address space. It talks to that memory through a synchronous byte-wide port: read data arrives one clock after the address is presented. Words are big-endian, so the lower address holds the high byte.

Instructions are either one byte long (unary) or three bytes long (nonunary). A nonunary instruction is a specifier byte followed by a 16-bit operand specifier. The core fetches every byte separately. It executes only a subset of the instruction set: stop, word load, byte load, word store, add, subtract, AND, OR, bitwise invert and two's-complement negate. The operand is addressed in immediate or direct mode only. Execution begins at address 0x0000 after reset.

The core halts on stop. It also halts on any encoding it does not support, and in that case it raises an illegal indication as well. Once halted, it stays halted until reset.

Top module: `acc_cpu`

## Requirements
- R1: While reset is low, and on its release, the core drives address 0x0000 and keeps write enable low. Its flags {N,Z,V,C} (flags_o bits 3..0) are 0000, and halted_o and illegal_o are low. The first specifier byte is fetched from 0x0000.
- R2: Word load (specifier 1100_r_mmm, where r = bit 3 selects A when 0 and X when 1, mode mmm = 000 immediate and 001 direct) puts the operand into register r. In immediate mode the operand is the operand specifier itself. In direct mode it is the word read big-endian at that address. N and Z are set from the result; V and C are unchanged.
- R3: Word store (1110_r_001) writes the high byte of register r at the operand address and the low byte at the next address, in two consecutive write cycles. It leaves all flags unchanged.
- R4: Byte load (1101_r_mmm) replaces only bits 7..0 of register r with the operand byte. In immediate mode that byte is the low byte of the operand specifier. N and Z come from the full 16-bit register.
- R5: Add (0111_r_mmm) and subtract (1000_r_mmm) write r+operand and r-operand. They set N and Z, set V on signed overflow, and set C to the carry out of r+operand or of r+~operand+1.
- R6: AND (1001_r_mmm) and OR (1010_r_mmm) write the bitwise result, set N and Z, and leave V and C unchanged.
- R7: Unary invert (0001_100_r) and negate (0001_101_r) complement or negate register r, where r = bit 0. They set N and Z, and the next instruction is fetched from the following byte.
- R8: Specifier 0x00 raises halted_o. halted_o then stays high until reset, with no further memory writes and no flag changes.
- R9: Any other unsupported specifier, any mode other than 000 or 001, and a store in immediate mode raise illegal_o together with halted_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 16 | Memory byte address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_we_o | output | 1 | Memory write enable |
| mem_rdata_i | input | 8 | Memory read data, valid one cycle after the address |
| halted_o | output | 1 | Core has stopped |
| illegal_o | output | 1 | Core stopped on an unsupported encoding |
| flags_o | output | 4 | Status flags {N,Z,V,C} |

## Verification
The assertions check four rules on every cycle. A halt is sticky. Illegal never appears without halted. A halted core neither writes nor changes its flags. Every store is exactly two write cycles to consecutive addresses, and the flags stay untouched across the store. The bench scenarios are the only way to show the arithmetic itself: the register contents seen through stores, the big-endian byte order, the partial update of a byte load, and the V and C results of add and subtract. The same holds for the one-byte length of unary instructions and for the decode of each illegal encoding.

// File: rtl/cpu_pkg.sv
package cpu_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 16;

  typedef enum logic [1:0] {K_STOP, K_UNARY, K_NONUN, K_ILL} kind_e;
  typedef enum logic [3:0] {
    OP_LD, OP_LDB, OP_ST, OP_ADD, OP_SUB, OP_AND, OP_OR, OP_NOT, OP_NEG
  } op_e;

  typedef struct packed {
    kind_e kind;
    op_e   op;
    logic  rsel;
    logic  direct;
  } dec_t;

  typedef enum logic [3:0] {
    S_F0, S_F1, S_O1, S_O2, S_R0, S_R1, S_R2, S_W0, S_W1, S_HALT
  } state_e;
endpackage

// File: rtl/cpu_decode.sv
module cpu_decode
  import cpu_pkg::*;
(
  input  logic [BYTE_W-1:0] spec_i,
  output dec_t              dec_o
);
  logic nonun;
  op_e  op_v;

  always_comb begin
    nonun = 1'b1;
    op_v  = OP_LD;
    unique case (spec_i[7:4])
      4'h7: op_v = OP_ADD;
      4'h8: op_v = OP_SUB;
      4'h9: op_v = OP_AND;
      4'hA: op_v = OP_OR;
      4'hC: op_v = OP_LD;
      4'hD: op_v = OP_LDB;
      4'hE: op_v = OP_ST;
      default: nonun = 1'b0;
    endcase
  end

  always_comb begin
    dec_o = '{kind: K_ILL, op: op_v, rsel: spec_i[3], direct: spec_i[0]};
    if (spec_i == '0) begin
      dec_o.kind = K_STOP;
    end else if (spec_i[7:2] == 6'b0001_10) begin
      dec_o.kind = K_UNARY;
      dec_o.op   = spec_i[1] ? OP_NEG : OP_NOT;
      dec_o.rsel = spec_i[0];
    end else if (nonun && spec_i[2:1] == 2'b00 && !(op_v == OP_ST && !spec_i[0])) begin
      dec_o.kind = K_NONUN;
    end
  end
endmodule

// File: rtl/cpu_alu.sv
module cpu_alu
  import cpu_pkg::*;
(
  input  op_e               op_i,
  input  logic [WORD_W-1:0] r_i,
  input  logic [WORD_W-1:0] b_i,
  input  logic [3:0]        flags_i,
  output logic [WORD_W-1:0] res_o,
  output logic [3:0]        flags_o
);
  logic [WORD_W-1:0] b_eff;
  logic [WORD_W:0]   sum;
  logic              is_arith;

  always_comb begin
    is_arith = (op_i == OP_ADD) || (op_i == OP_SUB);
    b_eff    = (op_i == OP_SUB) ? ~b_i : b_i;
    sum      = {1'b0, r_i} + {1'b0, b_eff} + {{WORD_W{1'b0}}, (op_i == OP_SUB)};
    unique case (op_i)
      OP_LD:   res_o = b_i;
      OP_LDB:  res_o = {r_i[WORD_W-1:BYTE_W], b_i[BYTE_W-1:0]};
      OP_AND:  res_o = r_i & b_i;
      OP_OR:   res_o = r_i | b_i;
      OP_NOT:  res_o = ~r_i;
      OP_NEG:  res_o = -r_i;
      OP_ADD, OP_SUB: res_o = sum[WORD_W-1:0];
      default: res_o = r_i;
    endcase
    flags_o    = flags_i;
    flags_o[3] = res_o[WORD_W-1];
    flags_o[2] = (res_o == '0);
    if (is_arith) begin
      flags_o[1] = (r_i[WORD_W-1] == b_eff[WORD_W-1]) && (res_o[WORD_W-1] != r_i[WORD_W-1]);
      flags_o[0] = sum[WORD_W];
    end
  end
endmodule

// File: rtl/cpu_regs.sv
module cpu_regs
  import cpu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              rsel_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [3:0]        flags_i,
  output logic [WORD_W-1:0] a_o,
  output logic [WORD_W-1:0] x_o,
  output logic [3:0]        flags_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_o     <= '0;
      x_o     <= '0;
      flags_o <= '0;
    end else if (we_i) begin
      if (rsel_i) x_o <= wdata_i;
      else        a_o <= wdata_i;
      flags_o <= flags_i;
    end
  end
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import cpu_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic              halted_o,
  output logic              illegal_o,
  output logic [3:0]        flags_o
);
  state_e            state_q, state_d;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [BYTE_W-1:0] ir_q, ir_d;
  logic [WORD_W-1:0] opnd_q, opnd_d;
  logic [BYTE_W-1:0] dhi_q, dhi_d;
  logic              ill_q, ill_d;

  logic [BYTE_W-1:0] dec_in;
  dec_t              dec;
  logic              exec;
  logic [WORD_W-1:0] exec_b, rval, alu_res, reg_a, reg_x;
  logic [3:0]        alu_flags;
  logic [ADDR_W-1:0] ea;

  assign dec_in = (state_q == S_F1) ? mem_rdata_i : ir_q;
  assign ea     = opnd_q;

  cpu_decode u_dec (.spec_i(dec_in), .dec_o(dec));

  assign rval = dec.rsel ? reg_x : reg_a;

  cpu_alu u_alu (
    .op_i(dec.op), .r_i(rval), .b_i(exec_b), .flags_i(flags_o),
    .res_o(alu_res), .flags_o(alu_flags)
  );

  cpu_regs u_regs (
    .clk_i, .rst_ni,
    .we_i(exec && dec.op != OP_ST), .rsel_i(dec.rsel),
    .wdata_i(alu_res), .flags_i(alu_flags),
    .a_o(reg_a), .x_o(reg_x), .flags_o(flags_o)
  );

  always_comb begin
    state_d     = state_q;
    pc_d        = pc_q;
    ir_d        = ir_q;
    opnd_d      = opnd_q;
    dhi_d       = dhi_q;
    ill_d       = ill_q;
    exec        = 1'b0;
    exec_b      = '0;
    mem_addr_o  = pc_q;
    mem_we_o    = 1'b0;
    mem_wdata_o = '0;
    unique case (state_q)
      S_F0: state_d = S_F1;
      S_F1: begin
        mem_addr_o = pc_q + ADDR_W'(1);
        ir_d       = mem_rdata_i;
        unique case (dec.kind)
          K_STOP:  state_d = S_HALT;
          K_ILL: begin
            state_d = S_HALT;
            ill_d   = 1'b1;
          end
          K_UNARY: begin
            exec    = 1'b1;
            pc_d    = pc_q + ADDR_W'(1);
            state_d = S_F0;
          end
          default: state_d = S_O1;
        endcase
      end
      S_O1: begin
        mem_addr_o             = pc_q + ADDR_W'(2);
        opnd_d[WORD_W-1:BYTE_W] = mem_rdata_i;
        state_d                = S_O2;
      end
      S_O2: begin
        pc_d               = pc_q + ADDR_W'(3);
        opnd_d[BYTE_W-1:0] = mem_rdata_i;
        if (!dec.direct) begin
          exec    = 1'b1;
          exec_b  = {opnd_q[WORD_W-1:BYTE_W], mem_rdata_i};
          state_d = S_F0;
        end else if (dec.op == OP_ST) begin
          state_d = S_W0;
        end else begin
          state_d = S_R0;
        end
      end
      S_R0: begin
        mem_addr_o = ea;
        state_d    = S_R1;
      end
      S_R1: begin
        mem_addr_o = ea + ADDR_W'(1);
        if (dec.op == OP_LDB) begin
          exec    = 1'b1;
          exec_b  = {{(WORD_W-BYTE_W){1'b0}}, mem_rdata_i};
          state_d = S_F0;
        end else begin
          dhi_d   = mem_rdata_i;
          state_d = S_R2;
        end
      end
      S_R2: begin
        exec    = 1'b1;
        exec_b  = {dhi_q, mem_rdata_i};
        state_d = S_F0;
      end
      S_W0: begin
        mem_addr_o  = ea;
        mem_we_o    = 1'b1;
        mem_wdata_o = rval[WORD_W-1:BYTE_W];
        state_d     = S_W1;
      end
      S_W1: begin
        mem_addr_o  = ea + ADDR_W'(1);
        mem_we_o    = 1'b1;
        mem_wdata_o = rval[BYTE_W-1:0];
        state_d     = S_F0;
      end
      default: state_d = S_HALT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_F0;
      pc_q    <= RESET_PC;
      ir_q    <= '0;
      opnd_q  <= '0;
      dhi_q   <= '0;
      ill_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      ir_q    <= ir_d;
      opnd_q  <= opnd_d;
      dhi_q   <= dhi_d;
      ill_q   <= ill_d;
    end
  end

  assign halted_o  = (state_q == S_HALT);
  assign illegal_o = ill_q;
endmodule

// File: rtl/acc_cpu_checker.sv
module acc_cpu_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] mem_addr_o,
  input logic        mem_we_o,
  input logic        halted_o,
  input logic        illegal_o,
  input logic [3:0]  flags_o
);
  a_r8_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o);
  a_r8_halt_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> !mem_we_o);
  a_r8_halt_flags_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> $stable(flags_o));
  a_r9_illegal_halts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> halted_o);
  a_r3_second_byte_next_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_o) |=> mem_we_o && (mem_addr_o == $past(mem_addr_o) + 16'd1));
  a_r3_two_writes_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && $past(mem_we_o)) |=> !mem_we_o);
  a_r3_store_keeps_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> $stable(flags_o));
endmodule

bind acc_cpu acc_cpu_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mem_addr_o(mem_addr_o), .mem_we_o(mem_we_o),
  .halted_o(halted_o), .illegal_o(illegal_o), .flags_o(flags_o)
);

// File: tb/acc_cpu_tb.sv
module acc_cpu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        mem_we, halted, illegal;
  logic [3:0]  flags;
  logic [7:0]  mem [0:65535];
  int          checks = 0, errors = 0, cycles = 0;

  always #4 clk = ~clk;

  acc_cpu u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_we_o(mem_we), .mem_rdata_i(mem_rdata), .halted_o(halted),
    .illegal_o(illegal), .flags_o(flags)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic start(input logic [7:0] prog[]);
    rst_n = 1'b0;
    for (int i = 0; i < 65536; i++) mem[i] = 8'h00;
    for (int i = 0; i < prog.size(); i++) mem[i] = prog[i];
    repeat (2) @(negedge clk);
  endtask

  task automatic run(string req);
    int n = 0;
    @(negedge clk) rst_n = 1'b1;
    while (!halted && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk({req, " halt reached"}, 16'(halted), 16'd1);
  endtask

  function automatic logic [15:0] word_at(int a);
    return {mem[a], mem[a+1]};
  endfunction

  task automatic t_reset();
    start('{8'h00});
    chk("R1 addr", mem_addr, 16'h0000);
    chk("R1 we", 16'(mem_we), 16'd0);
    chk("R1 flags", 16'(flags), 16'h0);
    chk("R1 halted", 16'(halted), 16'd0);
    chk("R1 illegal", 16'(illegal), 16'd0);
  endtask

  task automatic t_load();
    start('{8'hC1,8'h00,8'h40, 8'hE1,8'h00,8'h50, 8'hC8,8'h00,8'h00, 8'hE9,8'h00,8'h52, 8'h00});
    mem[16'h40] = 8'h92; mem[16'h41] = 8'hEF;
    mem[16'h52] = 8'h77; mem[16'h53] = 8'h77;
    run("R2");
    chk("R2 direct big-endian load", word_at('h50), 16'h92EF);
    chk("R2 immediate load X", word_at('h52), 16'h0000);
    chk("R2 Z from load", 16'(flags), 16'b0100);
    chk("R8 stop not illegal", 16'(illegal), 16'd0);
  endtask

  task automatic t_store();
    start('{8'hC8,8'h16,8'hBC, 8'hE9,8'h00,8'h4A, 8'h00});
    run("R3");
    chk("R3 high byte first", 16'(mem[16'h4A]), 16'h16);
    chk("R3 low byte next", 16'(mem[16'h4B]), 16'hBC);
    chk("R3 flags", 16'(flags), 16'b0000);
  endtask

  task automatic t_ldbyte();
    start('{8'hC0,8'h12,8'h34, 8'hD1,8'h00,8'h60, 8'hE1,8'h00,8'h70,
            8'hC0,8'hFF,8'h55, 8'hD0,8'h00,8'h00, 8'hE1,8'h00,8'h72, 8'h00});
    mem[16'h60] = 8'h80;
    run("R4");
    chk("R4 direct byte keeps high", word_at('h70), 16'h1280);
    chk("R4 immediate byte", word_at('h72), 16'hFF00);
    chk("R4 NZ from full word", 16'(flags), 16'b1000);
  endtask

  task automatic t_add();
    start('{8'hC0,8'h7F,8'hFF, 8'h70,8'h00,8'h01, 8'hE1,8'h00,8'h80, 8'h00});
    run("R5");
    chk("R5 add overflow result", word_at('h80), 16'h8000);
    chk("R5 add NV", 16'(flags), 16'b1010);
    start('{8'hC8,8'hFF,8'hFF, 8'h78,8'h00,8'h01, 8'hE9,8'h00,8'h80, 8'h00});
    mem[16'h80] = 8'h11;
    run("R5");
    chk("R5 add carry result", word_at('h80), 16'h0000);
    chk("R5 add ZC", 16'(flags), 16'b0101);
  endtask

  task automatic t_sub();
    start('{8'hC0,8'h00,8'h03, 8'h81,8'h00,8'h40, 8'hE1,8'h00,8'h80, 8'h00});
    mem[16'h40] = 8'h00; mem[16'h41] = 8'h09;
    run("R5");
    chk("R5 sub borrow result", word_at('h80), 16'hFFFA);
    chk("R5 sub N, C clear", 16'(flags), 16'b1000);
    start('{8'hC8,8'h00,8'h05, 8'h88,8'h00,8'h05, 8'hE9,8'h00,8'h82, 8'h00});
    mem[16'h82] = 8'h11;
    run("R5");
    chk("R5 sub equal result", word_at('h82), 16'h0000);
    chk("R5 sub Z, C set", 16'(flags), 16'b0101);
  endtask

  task automatic t_logic();
    start('{8'hC0,8'h7F,8'hFF, 8'h70,8'h00,8'h01, 8'hC8,8'h5D,8'hC3, 8'h98,8'h00,8'hFF,
            8'hE9,8'h00,8'h80, 8'hC8,8'h5D,8'hC3, 8'hA8,8'h00,8'hFF, 8'hE9,8'h00,8'h82, 8'h00});
    run("R6");
    chk("R6 and", word_at('h80), 16'h00C3);
    chk("R6 or", word_at('h82), 16'h5DFF);
    chk("R6 V kept, C kept", 16'(flags), 16'b0010);
  endtask

  task automatic t_unary();
    start('{8'hC0,8'h00,8'h03, 8'h18, 8'hE1,8'h00,8'h80,
            8'hC8,8'h00,8'h03, 8'h1B, 8'hE9,8'h00,8'h82, 8'h00});
    run("R7");
    chk("R7 invert A", word_at('h80), 16'hFFFC);
    chk("R7 negate X", word_at('h82), 16'hFFFD);
    chk("R7 flags", 16'(flags), 16'b1000);
  endtask

  task automatic t_stop();
    start('{8'hC0,8'h12,8'h34, 8'h00, 8'hE1,8'h00,8'h90});
    mem[16'h90] = 8'h55;
    run("R8");
    repeat (20) @(negedge clk);
    chk("R8 stays halted", 16'(halted), 16'd1);
    chk("R8 no execution after stop", 16'(mem[16'h90]), 16'h55);
    chk("R8 not illegal", 16'(illegal), 16'd0);
  endtask

  task automatic t_illegal();
    start('{8'hB0,8'h00,8'h00});
    run("R9");
    chk("R9 unsupported opcode", 16'(illegal), 16'd1);
    start('{8'hC2,8'h00,8'h00});
    run("R9");
    chk("R9 unsupported mode", 16'(illegal), 16'd1);
    start('{8'hC8,8'h12,8'h34, 8'hE8,8'h00,8'h20, 8'hE9,8'h00,8'h30});
    mem[16'h30] = 8'h66;
    run("R9");
    chk("R9 store immediate", 16'(illegal), 16'd1);
    chk("R9 no store after illegal", 16'(mem[16'h30]), 16'h66);
  endtask

  initial begin
    t_reset();
    t_load();
    t_store();
    t_ldbyte();
    t_add();
    t_sub();
    t_logic();
    t_unary();
    t_stop();
    t_illegal();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule